// File: doc/BRIEF.md
# Asynchronous SRAM bus cycle controller

This block sits on the host side of a byte-wide asynchronous static RAM with a 21-bit address and 8-bit data. It takes single read or write requests from a valid/ready interface and turns each into a correctly timed sequence on the memory's active-low chip enable, output enable and write enable lines. The bidirectional data bus is split into a drive value, a drive enable and a sampled input, so the pad that merges them stays outside the block.

Every memory timing figure is a nanosecond parameter. The block converts each one into whole clock cycles from a clock-period parameter, using the ceiling of the ratio. Where an interval must be non-zero, the count is at least one cycle. Reads capture the data bus at the end of the access window and return it with a one-cycle done pulse. Writes are shaped by the write enable line. Output enable stays high for the whole write, and the data bus is driven only while write enable is low.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. It stays low from the accepting edge until the whole memory cycle, recovery included, has finished. While `req_ready` is low, the host must hold its request, and the block ignores it. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse that the host must take when it appears.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A request is accepted only when `req_valid` and `req_ready` are both 1. From the accepting edge, `req_ready` stays 0 for 10 cycles for a read and 8 cycles for a write (10 ns clock). A request held valid during that time starts no second memory cycle.
- R3: A read drives `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 with a stable address for ceil(max(70,70,35,70) ns / period) = 7 cycles. The data bus is captured at the end of that window and returned on `rsp_rdata` with a one-cycle `rsp_valid` pulse.
- R4: After a read, chip enable and output enable stay high and the data bus is not driven for at least ceil(max(25,30) ns / period) = 3 cycles before any new memory cycle starts.
- R5: `mem_oe_n` is 1 in every cycle where `mem_we_n` is 0.
- R6: A write presents the address with `mem_ce_n`=0 for one cycle before `mem_we_n` falls. `mem_we_n` is then low for exactly max(ceil(55/T), ceil(65/T)-1, ceil(30/T), ceil(70/T)-2) = 6 cycles. The address is therefore valid at least 65 ns before `mem_we_n` rises.
- R7: `mem_dq_oe` is 1 only while `mem_we_n` is 0, and drops in the same cycle that `mem_we_n` rises. Write data is therefore driven at least 30 ns before that rise.
- R8: After `mem_we_n` rises, the address and `mem_ce_n`=0 are held for one more cycle. The address never changes while `mem_ce_n` stays 0.
- R9: Data written at an address, including address 0 and address 0x1FFFFF, is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read done pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid |
| mem_addr | output | 21 | Memory address lines |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Host drives the data bus when 1 |
| mem_dq_in | input | 8 | Value sampled from the data bus |

## Verification
The bench's memory model returns a poison byte until chip enable and output enable have been low for the full access window. A controller that samples one cycle early therefore returns 0xEE instead of the stored byte. The model also measures each write enable pulse, the address and data setup before its rising edge, and any output enable low during a write. A shortened pulse, a drive enable that outlives write enable, or a controller that drives the bus while the memory still does is reported at that edge. Each request's busy window is counted, and requests are held valid through it, so a wrong recovery count or a request taken twice shows up as a bad window length or an extra write. Writes at both ends of the address range, followed by readback, catch truncated address paths.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_RD_TURN  = 3'd2,
    ST_WR_SETUP = 3'd3,
    ST_WR_PULSE = 3'd4,
    ST_WR_HOLD  = 3'd5
  } cyc_state_t;

  // ceiling of ns / clk_ns, optionally forced to at least one cycle
  function automatic int ns_to_cyc(input int ns, input int clk_ns, input bit min_one);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (min_one && c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_interval_timer.sv
module sram_interval_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == '0) |=> (cnt == '0)) else $error("timer wrapped"); // R2

endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
  parameter int AW = 21,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (take) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end

endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int               CNT_W  = 4,
  parameter logic [CNT_W-1:0] LD_RD  = '0,
  parameter logic [CNT_W-1:0] LD_TRN = '0,
  parameter logic [CNT_W-1:0] LD_SU  = '0,
  parameter logic [CNT_W-1:0] LD_WP  = '0,
  parameter logic [CNT_W-1:0] LD_HLD = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_expired,
  output cyc_state_t       state,
  output logic             accept,
  output logic             capture,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  cyc_state_t nxt;

  always_comb begin
    nxt      = state;
    accept   = 1'b0;
    capture  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        accept   = 1'b1;
        tmr_load = 1'b1;
        if (req_write) begin
          nxt     = ST_WR_SETUP;
          tmr_val = LD_SU;
        end else begin
          nxt     = ST_RD_ACC;
          tmr_val = LD_RD;
        end
      end
      ST_RD_ACC: if (tmr_expired) begin
        nxt      = ST_RD_TURN;
        capture  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = LD_TRN;
      end
      ST_RD_TURN: if (tmr_expired) nxt = ST_IDLE;
      ST_WR_SETUP: if (tmr_expired) begin
        nxt      = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = LD_WP;
      end
      ST_WR_PULSE: if (tmr_expired) begin
        nxt      = ST_WR_HOLD;
        tmr_load = 1'b1;
        tmr_val  = LD_HLD;
      end
      ST_WR_HOLD: if (tmr_expired) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  AST_PULSE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR_PULSE && $past(state) != ST_WR_PULSE) |-> ($past(state) == ST_WR_SETUP))
    else $error("write pulse without setup"); // R6

  AST_HOLD_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR_HOLD && $past(state) != ST_WR_HOLD) |-> ($past(state) == ST_WR_PULSE))
    else $error("hold without pulse"); // R8

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW          = 21,
  parameter int DW          = 8,
  parameter int CLK_NS      = 10,
  parameter int T_CYCLE     = 70,
  parameter int T_ACC_ADDR  = 70,
  parameter int T_ACC_CE    = 70,
  parameter int T_ACC_OE    = 35,
  parameter int T_WE_WIDTH  = 55,
  parameter int T_ADDR_WEUP = 65,
  parameter int T_DATA_WEUP = 30,
  parameter int T_ADDR_WEDN = 0,
  parameter int T_ADDR_HOLD = 5,
  parameter int T_OE_FLOAT  = 25,
  parameter int T_CE_FLOAT  = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  // interval counts in clock cycles
  localparam int N_RD  = max2(max2(ns_to_cyc(T_ACC_ADDR, CLK_NS, 1'b1), ns_to_cyc(T_ACC_CE, CLK_NS, 1'b1)),
                              max2(ns_to_cyc(T_ACC_OE, CLK_NS, 1'b1), ns_to_cyc(T_CYCLE, CLK_NS, 1'b1)));
  localparam int N_TRN = max2(ns_to_cyc(T_OE_FLOAT, CLK_NS, 1'b1), ns_to_cyc(T_CE_FLOAT, CLK_NS, 1'b1));
  localparam int N_SU  = ns_to_cyc(T_ADDR_WEDN, CLK_NS, 1'b1);
  localparam int N_HLD = ns_to_cyc(T_ADDR_HOLD, CLK_NS, 1'b1);
  localparam int N_WP  = max2(max2(ns_to_cyc(T_WE_WIDTH, CLK_NS, 1'b1),
                                   ns_to_cyc(T_ADDR_WEUP, CLK_NS, 1'b1) - N_SU),
                              max2(ns_to_cyc(T_DATA_WEUP, CLK_NS, 1'b1),
                                   ns_to_cyc(T_CYCLE, CLK_NS, 1'b1) - N_SU - N_HLD));
  localparam int N_MAX = max2(max2(N_RD, N_TRN), max2(max2(N_SU, N_HLD), N_WP));
  localparam int CNT_W = $clog2(N_MAX + 1);

  localparam logic [CNT_W-1:0] LD_RD  = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] LD_TRN = CNT_W'(N_TRN - 1);
  localparam logic [CNT_W-1:0] LD_SU  = CNT_W'(N_SU - 1);
  localparam logic [CNT_W-1:0] LD_WP  = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] LD_HLD = CNT_W'(N_HLD - 1);

  cyc_state_t       state;
  logic             accept, capture, tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;

  sram_cycle_fsm #(
    .CNT_W(CNT_W), .LD_RD(LD_RD), .LD_TRN(LD_TRN),
    .LD_SU(LD_SU), .LD_WP(LD_WP), .LD_HLD(LD_HLD)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .tmr_expired(tmr_expired), .state(state), .accept(accept),
    .capture(capture), .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  sram_interval_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  sram_req_latch #(.AW(AW), .DW(DW)) u_lat (
    .clk(clk), .rst_n(rst_n), .take(accept), .addr_in(req_addr),
    .data_in(req_wdata), .addr_q(mem_addr), .data_q(mem_dq_out)
  );

  // pin decode from the registered state
  always_comb begin
    mem_ce_n  = 1'b1;
    mem_oe_n  = 1'b1;
    mem_we_n  = 1'b1;
    mem_dq_oe = 1'b0;
    unique case (state)
      ST_RD_ACC:   begin mem_ce_n = 1'b0; mem_oe_n = 1'b0; end
      ST_WR_SETUP: mem_ce_n = 1'b0;
      ST_WR_PULSE: begin mem_ce_n = 1'b0; mem_we_n = 1'b0; mem_dq_oe = 1'b1; end
      ST_WR_HOLD:  mem_ce_n = 1'b0;
      default:     ;
    endcase
  end

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= mem_dq_in;
    end
  end

  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n) else $error("oe low during write"); // R5

  AST_DQ_ONLY_WE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n)) else $error("bus driven outside write pulse"); // R7

  AST_ADDR_STABLE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)) else $error("address moved under ce"); // R8

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid) else $error("done pulse too long"); // R3

  AST_READY_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_dq_oe)) else $error("ready during a cycle"); // R2

endmodule

// File: tb/sim_sram_cycle_ctrl.sv
module sim_sram_cycle_ctrl;
  localparam int CLK_PERIOD_NS = 10;
  localparam int AW = 21;
  localparam int DW = 8;

  function automatic int cdiv(input int ns);
    return (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  endfunction

  localparam int RD_CYC  = 7;   // R3
  localparam int TRN_CYC = 3;   // R4
  localparam int WP_CYC  = 6;   // R6
  localparam int RD_BUSY = RD_CYC + TRN_CYC;
  localparam int WR_BUSY = 1 + WP_CYC + 1;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = 8'hEE;

  always #(CLK_PERIOD_NS/2) clk = ~clk;

  sram_cycle_ctrl #(.CLK_NS(CLK_PERIOD_NS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [DW-1:0] mdl [logic [AW-1:0]];
  logic [DW-1:0] shadow [logic [AW-1:0]];
  int   writes = 0;
  bit   prev_we = 1, prev_ce_low = 0, prev_dq = 0, seen_read = 0;
  int   we_cnt = 0, dq_cnt = 0, stab = 0, acc = 0, float_cnt = 0;
  logic [AW-1:0] last_addr = '0, wr_addr = '0;
  logic [DW-1:0] wr_data = '0;

  always @(posedge clk) if (rst_n) begin
    if (!mem_we_n && !mem_oe_n) chk(0, "R5", "oe low during write", 0, 1);
    if (mem_dq_oe && (mem_we_n || !mem_oe_n)) chk(0, "R7", "bus driven outside pulse", 1, 0);
    if (!mem_ce_n && prev_ce_low && mem_addr != last_addr) chk(0, "R8", "addr moved under ce", int'(mem_addr), int'(last_addr));
    if (mem_we_n && !prev_we) begin
      chk(we_cnt == WP_CYC, "R6", "we pulse cycles", we_cnt, WP_CYC);
      chk(we_cnt * CLK_PERIOD_NS >= 55, "R6", "we pulse ns", we_cnt * CLK_PERIOD_NS, 55);
      chk((stab + 1) * CLK_PERIOD_NS >= 65, "R6", "addr setup to we rise", (stab + 1) * CLK_PERIOD_NS, 65);
      chk(dq_cnt * CLK_PERIOD_NS >= 30, "R7", "data setup to we rise", dq_cnt * CLK_PERIOD_NS, 30);
      chk(!mem_dq_oe, "R7", "dq_oe drops with we", int'(mem_dq_oe), 0);
      chk(!mem_ce_n && mem_addr == wr_addr, "R8", "hold after we rise", int'(mem_addr), int'(wr_addr));
      mdl[wr_addr] = wr_data;
      writes++;
    end
    if (mem_dq_oe && !prev_dq && seen_read)
      chk(float_cnt >= TRN_CYC, "R4", "bus turnaround cycles", float_cnt, TRN_CYC);
    if (!mem_we_n) begin we_cnt <= we_cnt + 1; wr_addr <= mem_addr; wr_data <= mem_dq_out; end
    else we_cnt <= 0;
    dq_cnt <= mem_dq_oe ? dq_cnt + 1 : 0;
    stab <= (mem_addr == last_addr) ? stab + 1 : 0;
    acc <= (!mem_ce_n && !mem_oe_n && mem_we_n) ? acc + 1 : 0;
    if (!mem_oe_n) begin float_cnt <= 0; seen_read <= 1; end
    else if (!mem_dq_oe) float_cnt <= float_cnt + 1;
    last_addr <= mem_addr;
    prev_we <= mem_we_n;
    prev_ce_low <= !mem_ce_n;
    prev_dq <= mem_dq_oe;
  end

  // data appears only once the access window has elapsed (R3)
  always @(negedge clk) begin
    if (acc >= RD_CYC - 1 && !mem_oe_n)
      mem_dq_in <= mdl.exists(mem_addr) ? mdl[mem_addr] : 8'h00;
    else
      mem_dq_in <= 8'hEE;
  end

  // ---------------- scoreboard ----------------
  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } exp_t;
  exp_t q[$];
  bit prev_rsp = 0;

  always @(negedge clk) if (rst_n) begin
    if (rsp_valid && prev_rsp) chk(0, "R3", "done pulse longer than one cycle", 2, 1);
    if (rsp_valid) begin
      if (q.size() == 0) chk(0, "R3", "unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(rsp_rdata == e.d, (e.a == '0 || e.a == '1) ? "R9" : "R3", "read data", int'(rsp_rdata), int'(e.d));
      end
    end
    prev_rsp <= rsp_valid;
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit hold_valid, output int busy);
    exp_t e;
    while (!req_ready) @(negedge clk);
    if (wr) shadow[a] = d;
    else begin
      e.a = a;
      e.d = shadow.exists(a) ? shadow[a] : 8'h00;
      q.push_back(e);
    end
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (!hold_valid) req_valid = 1'b0;
    busy = 0;
    while (!req_ready) begin busy++; @(negedge clk); end
    req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD_NS * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int b, w0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1", "ready", int'(req_ready), 1);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", "enables high", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dq_oe, "R1", "dq_oe", int'(mem_dq_oe), 0);
    chk(!rsp_valid, "R1", "rsp_valid", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    issue(1, 21'h000000, 8'h5A, 0, b);
    chk(b == WR_BUSY, "R2", "write busy cycles", b, WR_BUSY);
    issue(0, 21'h000000, 8'h00, 0, b);
    chk(b == RD_BUSY, "R2", "read busy cycles", b, RD_BUSY);
    issue(1, 21'h1FFFFF, 8'hA5, 0, b);
    issue(0, 21'h1FFFFF, 8'h00, 0, b);   // R9 top of range

    for (int i = 0; i < 6; i++) issue(1, 21'(32'h1234 * (i + 1)), 8'(8'h11 * i + 3), 0, b);
    for (int i = 5; i >= 0; i--) issue(0, 21'(32'h1234 * (i + 1)), 8'h00, 0, b);

    // R2: request held valid through busy window starts one cycle only
    w0 = writes;
    issue(1, 21'h0ABCDE, 8'h3C, 1, b);
    chk(writes == w0 + 1, "R2", "held request writes", writes - w0, 1);
    chk(b == WR_BUSY, "R2", "held write busy", b, WR_BUSY);
    issue(0, 21'h0ABCDE, 8'h00, 1, b);
    chk(b == RD_BUSY, "R2", "held read busy", b, RD_BUSY);

    // R4: write immediately after read, read of unwritten address
    issue(0, 21'h000777, 8'h00, 0, b);
    issue(1, 21'h000777, 8'hC3, 0, b);
    issue(0, 21'h000777, 8'h00, 0, b);
    issue(1, 21'h000000, 8'hFF, 0, b);
    issue(0, 21'h000000, 8'h00, 0, b);   // R9 overwrite at bottom

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R3", "outstanding reads", q.size(), 0);
    chk(req_ready && mem_ce_n, "R1", "idle at end", int'(req_ready), 1);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule